// File: doc/BRIEF.md
# Reordering DRAM Request Picker

This block decides which pending DRAM request a memory controller issues next. It looks at every entry of a small request queue and at the state of every bank, then returns the queue position of the winner and a flag that says whether any entry qualified. Each entry carries a rank, a bank and a row. For each bank the block sees whether a row is open and which one, and the earliest times at which a column command, an activate and a precharge may be sent. The controller then moves the chosen entry to the head of its queue, issues the commands and updates the bank timers. None of that happens inside this block.

The choice follows a ladder of four classes. First come row hits whose column command can go out back to back with the burst now on the data bus. Next comes a row miss whose activate fits inside the time the bus is already busy. Then comes a row hit that must wait. Last comes the miss to the bank that is ready soonest. Within a class the oldest queue position wins. When the bus has just turned around, a turnaround penalty is added to the column window. The penalty differs for reads and for writes.

A decision is taken in the cycle in which `eval_i` is high. It is registered and appears on the outputs one clock later.

Top module: `frf_pick_sel`

## Requirements
- R1: After reset, `pick_found_o`, `pick_idx_o` and `done_o` are all zero.
- R2: When `eval_i` is high at a clock edge, `done_o` is 1 after that edge, and the outputs show the decision for the inputs sampled at that edge. When `eval_i` is low, `done_o` is 0 and `pick_found_o` and `pick_idx_o` hold their values, whatever the other inputs do.
- R3: The column window is W = max(bus_busy + gap − t_cl, now), computed without wrap-around. When bus_busy + gap is below t_cl, W equals now.
- R4: The gap is 0 when `dir_switch_i` is 0. It is t_cs for reads (`for_writes_i`=0) and min(t_rtw, t_cs) for writes (`for_writes_i`=1).
- R5: An entry is eligible only if its valid bit is 1 and the bit of `rank_avail_i` at its rank index is 1. If no eligible entry qualifies, `pick_found_o` is 0.
- R6: A row hit means the bank (id = rank × BPR + bank) has its open bit set and its open row equals the entry's row. A row hit whose bank column-allowed time is ≤ W beats every other candidate, and the first such hit in queue order (index 0 is oldest) wins.
- R7: A bank's activate time A is max(pre_ok, now) + t_rp if a row is open, and max(act_ok, now) if not. Its column time C is max(col_ok, A + t_rcd).
- R8: Only banks named by at least one valid entry, on any rank, form the ready set. If any such bank has C ≤ W, the ready set holds exactly those banks. Otherwise it holds the waiting banks that share the smallest A.
- R9: A miss is hidden when A ≤ max(W − t_rcd, now), computed without wrap-around. A hidden candidate miss beats non-seamless row hits. A non-hidden candidate miss loses to any non-seamless row hit, whether that hit is earlier or later in the queue.
- R10: Only the first eligible miss in queue order whose bank is in the ready set is a miss candidate. Among equal-class candidates the lowest queue index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| eval_i | input | 1 | Take a decision at this edge |
| q_valid_i | input | QD | Entry occupied, bit i for position i (0 oldest) |
| q_rank_i | input | QD×RW | Rank of each entry |
| q_bank_i | input | QD×BW | Bank within rank of each entry |
| q_row_i | input | QD×ROW_W | Row of each entry |
| rank_avail_i | input | NR | Rank may take commands |
| bk_open_i | input | NB | Bank has an open row |
| bk_row_i | input | NB×ROW_W | Open row per bank |
| bk_col_ok_i | input | NB×TW | Earliest column time per bank |
| bk_act_ok_i | input | NB×TW | Earliest activate time per bank |
| bk_pre_ok_i | input | NB×TW | Earliest precharge time per bank |
| now_i | input | TW | Current time |
| bus_busy_i | input | TW | Data bus busy until |
| t_cl_i | input | TW | Column-to-data latency |
| t_rcd_i | input | TW | Activate-to-column delay |
| t_rp_i | input | TW | Precharge time |
| t_cs_i | input | TW | Rank switch penalty |
| t_rtw_i | input | TW | Read-to-write penalty |
| dir_switch_i | input | 1 | Bus direction just changed |
| for_writes_i | input | 1 | Queue being scanned holds writes |
| pick_found_o | output | 1 | A request was chosen |
| pick_idx_o | output | QW | Queue position chosen |
| done_o | output | 1 | Decision registered this cycle |

## Verification
The main sweep feeds a few thousand random queue and bank pictures. The times are kept small so that row hits, ties, saturated windows and turnaround penalties all occur often. Each result is compared with a class-ranking model that scores every entry and takes the minimum, which is a different formulation from the design's priority scan. Hand-built cases each isolate one rule: they separate the read and write turnaround gaps, the saturated window, an activate with and without the precharge term, the precedence of seamless banks over earlier activates, the exclusion of idle banks from the ready set, and the hidden and non-hidden miss in both queue orders. Hold cycles change every input while `eval_i` is low, to show that the registered decision stays put.

// File: rtl/frf_sel_pkg.sv
package frf_sel_pkg;
  typedef enum logic [1:0] {
    WIN_SEAMLESS = 2'd0,
    WIN_HIDDEN   = 2'd1,
    WIN_PREPPED  = 2'd2,
    WIN_EARLIEST = 2'd3
  } win_kind_e;
endpackage

// File: rtl/frf_col_window.sv
module frf_col_window #(
  parameter int TW = 8,
  parameter int EW = TW + 2
) (
  input  logic [TW-1:0] now_i,
  input  logic [TW-1:0] bus_busy_i,
  input  logic [TW-1:0] t_cl_i,
  input  logic [TW-1:0] t_rcd_i,
  input  logic [TW-1:0] t_cs_i,
  input  logic [TW-1:0] t_rtw_i,
  input  logic          dir_switch_i,
  input  logic          for_writes_i,
  output logic [EW-1:0] min_col_o,
  output logic [EW-1:0] hid_act_o
);
  logic [TW-1:0] gap_n;
  logic [EW-1:0] sum_n, lift_n, win_n, back_n;

  always_comb begin
    gap_n = '0;
    if (dir_switch_i) begin
      if (for_writes_i) gap_n = (t_rtw_i < t_cs_i) ? t_rtw_i : t_cs_i;
      else              gap_n = t_cs_i;
    end
    sum_n  = EW'(bus_busy_i) + EW'(gap_n);
    lift_n = (sum_n >= EW'(t_cl_i)) ? (sum_n - EW'(t_cl_i)) : '0;
    win_n  = (lift_n > EW'(now_i)) ? lift_n : EW'(now_i);
    back_n = (win_n >= EW'(t_rcd_i)) ? (win_n - EW'(t_rcd_i)) : '0;
  end

  assign min_col_o = win_n;
  assign hid_act_o = (back_n > EW'(now_i)) ? back_n : EW'(now_i);
endmodule

// File: rtl/frf_bank_mask.sv
module frf_bank_mask #(
  parameter int QD    = 4,
  parameter int NR    = 2,
  parameter int BPR   = 2,
  parameter int TW    = 8,
  parameter int RW    = (NR > 1) ? $clog2(NR) : 1,
  parameter int BW    = $clog2(BPR),
  parameter int NB    = NR * BPR,
  parameter int EW    = TW + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [QD-1:0]          q_valid_i,
  input  logic [QD-1:0][RW-1:0]  q_rank_i,
  input  logic [QD-1:0][BW-1:0]  q_bank_i,
  input  logic [NB-1:0]          bk_open_i,
  input  logic [NB-1:0][TW-1:0]  bk_col_ok_i,
  input  logic [NB-1:0][TW-1:0]  bk_act_ok_i,
  input  logic [NB-1:0][TW-1:0]  bk_pre_ok_i,
  input  logic [TW-1:0]          now_i,
  input  logic [TW-1:0]          t_rp_i,
  input  logic [TW-1:0]          t_rcd_i,
  input  logic [EW-1:0]          min_col_i,
  input  logic [EW-1:0]          hid_act_i,
  output logic [NB-1:0]          mask_o,
  output logic [NB-1:0]          hidden_o
);
  logic [NB-1:0]         wait_n;
  logic [NB-1:0]         seam_n;
  logic [NB-1:0][EW-1:0] act_at;
  logic [NB-1:0][EW-1:0] col_at;
  logic [EW-1:0]         least_n;

  // banks named by any valid entry, regardless of rank availability
  always_comb begin
    wait_n = '0;
    for (int i = 0; i < QD; i++)
      if (q_valid_i[i]) wait_n[{q_rank_i[i], q_bank_i[i]}] = 1'b1;
  end

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic [EW-1:0] pre_lim, act_lim, col_min;
    assign pre_lim  = (bk_pre_ok_i[g] > now_i) ? EW'(bk_pre_ok_i[g]) : EW'(now_i);
    assign act_lim  = (bk_act_ok_i[g] > now_i) ? EW'(bk_act_ok_i[g]) : EW'(now_i);
    assign act_at[g] = bk_open_i[g] ? (pre_lim + EW'(t_rp_i)) : act_lim;
    assign col_min  = act_at[g] + EW'(t_rcd_i);
    assign col_at[g] = (EW'(bk_col_ok_i[g]) > col_min) ? EW'(bk_col_ok_i[g]) : col_min;
    assign seam_n[g] = wait_n[g] && (col_at[g] <= min_col_i);
    assign hidden_o[g] = (act_at[g] <= hid_act_i);
  end

  always_comb begin
    least_n = '1;
    for (int b = 0; b < NB; b++)
      if (wait_n[b] && (act_at[b] < least_n)) least_n = act_at[b];
    for (int b = 0; b < NB; b++)
      mask_o[b] = (|seam_n) ? seam_n[b] : (wait_n[b] && (act_at[b] == least_n));
  end

  // R8: any valid entry leaves at least one bank in the ready set
  p_mask_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|q_valid_i) |-> (|mask_o));
endmodule

// File: rtl/frf_queue_scan.sv
module frf_queue_scan
  import frf_sel_pkg::*;
#(
  parameter int QD    = 4,
  parameter int NR    = 2,
  parameter int BPR   = 2,
  parameter int ROW_W = 4,
  parameter int TW    = 8,
  parameter int RW    = (NR > 1) ? $clog2(NR) : 1,
  parameter int BW    = $clog2(BPR),
  parameter int NB    = NR * BPR,
  parameter int QW    = $clog2(QD),
  parameter int EW    = TW + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [QD-1:0]           q_valid_i,
  input  logic [QD-1:0][RW-1:0]   q_rank_i,
  input  logic [QD-1:0][BW-1:0]   q_bank_i,
  input  logic [QD-1:0][ROW_W-1:0] q_row_i,
  input  logic [NR-1:0]           rank_avail_i,
  input  logic [NB-1:0]           bk_open_i,
  input  logic [NB-1:0][ROW_W-1:0] bk_row_i,
  input  logic [NB-1:0][TW-1:0]   bk_col_ok_i,
  input  logic [EW-1:0]           min_col_i,
  input  logic [NB-1:0]           mask_i,
  input  logic [NB-1:0]           hidden_i,
  output logic                    found_o,
  output logic [QW-1:0]           idx_o,
  output win_kind_e               kind_o
);
  logic [RW+BW-1:0] bid;
  logic stop, got_prep, got_early, got_hid;

  always_comb begin
    found_o = 1'b0; idx_o = '0; kind_o = WIN_EARLIEST; bid = '0;
    stop = 1'b0; got_prep = 1'b0; got_early = 1'b0; got_hid = 1'b0;
    for (int i = 0; i < QD; i++) begin
      if (!stop && q_valid_i[i] && rank_avail_i[q_rank_i[i]]) begin
        bid = {q_rank_i[i], q_bank_i[i]};
        if (bk_open_i[bid] && (bk_row_i[bid] == q_row_i[i])) begin
          if (EW'(bk_col_ok_i[bid]) <= min_col_i) begin
            found_o = 1'b1; idx_o = i[QW-1:0]; kind_o = WIN_SEAMLESS; stop = 1'b1;
          end else if (!got_hid && !got_prep) begin
            found_o = 1'b1; idx_o = i[QW-1:0]; kind_o = WIN_PREPPED; got_prep = 1'b1;
          end
        end else if (!got_early && mask_i[bid]) begin
          got_early = 1'b1;
          got_hid   = hidden_i[bid];
          if (hidden_i[bid] || !got_prep) begin
            found_o = 1'b1; idx_o = i[QW-1:0];
            kind_o  = hidden_i[bid] ? WIN_HIDDEN : WIN_EARLIEST;
          end
        end
      end
    end
  end

  // R10: a chosen miss always targets a bank of the ready set
  p_miss_in_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (found_o && (kind_o == WIN_HIDDEN || kind_o == WIN_EARLIEST))
      |-> mask_i[{q_rank_i[idx_o], q_bank_i[idx_o]}]);
  // R9: a miss ranked as hidden really has a hidden activate
  p_hidden_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (found_o && kind_o == WIN_HIDDEN) |-> hidden_i[{q_rank_i[idx_o], q_bank_i[idx_o]}]);
endmodule

// File: rtl/frf_pick_sel.sv
module frf_pick_sel
  import frf_sel_pkg::*;
#(
  parameter int QD    = 4,
  parameter int NR    = 2,
  parameter int BPR   = 2,
  parameter int ROW_W = 4,
  parameter int TW    = 8,
  parameter int RW    = (NR > 1) ? $clog2(NR) : 1,
  parameter int BW    = $clog2(BPR),
  parameter int NB    = NR * BPR,
  parameter int QW    = $clog2(QD)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     eval_i,
  input  logic [QD-1:0]            q_valid_i,
  input  logic [QD-1:0][RW-1:0]    q_rank_i,
  input  logic [QD-1:0][BW-1:0]    q_bank_i,
  input  logic [QD-1:0][ROW_W-1:0] q_row_i,
  input  logic [NR-1:0]            rank_avail_i,
  input  logic [NB-1:0]            bk_open_i,
  input  logic [NB-1:0][ROW_W-1:0] bk_row_i,
  input  logic [NB-1:0][TW-1:0]    bk_col_ok_i,
  input  logic [NB-1:0][TW-1:0]    bk_act_ok_i,
  input  logic [NB-1:0][TW-1:0]    bk_pre_ok_i,
  input  logic [TW-1:0]            now_i,
  input  logic [TW-1:0]            bus_busy_i,
  input  logic [TW-1:0]            t_cl_i,
  input  logic [TW-1:0]            t_rcd_i,
  input  logic [TW-1:0]            t_rp_i,
  input  logic [TW-1:0]            t_cs_i,
  input  logic [TW-1:0]            t_rtw_i,
  input  logic                     dir_switch_i,
  input  logic                     for_writes_i,
  output logic                     pick_found_o,
  output logic [QW-1:0]            pick_idx_o,
  output logic                     done_o
);
  localparam int EW = TW + 2;

  logic [1:0]    rst_sync_q;
  logic          rst_q_n;
  logic [EW-1:0] min_col, hid_act;
  logic [NB-1:0] mask, hidden;
  logic          found_c;
  logic [QW-1:0] idx_c;
  win_kind_e     kind_c;
  logic          found_q, found_n, done_q, done_n;
  logic [QW-1:0] idx_q, idx_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  frf_col_window #(.TW(TW)) u_win (
    .now_i(now_i), .bus_busy_i(bus_busy_i), .t_cl_i(t_cl_i), .t_rcd_i(t_rcd_i),
    .t_cs_i(t_cs_i), .t_rtw_i(t_rtw_i), .dir_switch_i(dir_switch_i),
    .for_writes_i(for_writes_i), .min_col_o(min_col), .hid_act_o(hid_act));

  frf_bank_mask #(.QD(QD), .NR(NR), .BPR(BPR), .TW(TW)) u_mask (
    .clk(clk), .rst_n(rst_q_n), .q_valid_i(q_valid_i), .q_rank_i(q_rank_i),
    .q_bank_i(q_bank_i), .bk_open_i(bk_open_i), .bk_col_ok_i(bk_col_ok_i),
    .bk_act_ok_i(bk_act_ok_i), .bk_pre_ok_i(bk_pre_ok_i), .now_i(now_i),
    .t_rp_i(t_rp_i), .t_rcd_i(t_rcd_i), .min_col_i(min_col), .hid_act_i(hid_act),
    .mask_o(mask), .hidden_o(hidden));

  frf_queue_scan #(.QD(QD), .NR(NR), .BPR(BPR), .ROW_W(ROW_W), .TW(TW)) u_scan (
    .clk(clk), .rst_n(rst_q_n), .q_valid_i(q_valid_i), .q_rank_i(q_rank_i),
    .q_bank_i(q_bank_i), .q_row_i(q_row_i), .rank_avail_i(rank_avail_i),
    .bk_open_i(bk_open_i), .bk_row_i(bk_row_i), .bk_col_ok_i(bk_col_ok_i),
    .min_col_i(min_col), .mask_i(mask), .hidden_i(hidden),
    .found_o(found_c), .idx_o(idx_c), .kind_o(kind_c));

  always_comb begin
    found_n = found_q;
    idx_n   = idx_q;
    done_n  = 1'b0;
    if (eval_i) begin
      found_n = found_c;
      idx_n   = idx_c;
      done_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      found_q <= 1'b0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      found_q <= found_n;
      idx_q   <= idx_n;
      done_q  <= done_n;
    end
  end

  assign pick_found_o = found_q;
  assign pick_idx_o   = idx_q;
  assign done_o       = done_q;

  // R5: the winner is a valid entry on an available rank
  p_pick_eligible_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    found_c |-> (q_valid_i[idx_c] && rank_avail_i[q_rank_i[idx_c]]));
  // R6: a seamless winner has its column time inside the window
  p_seamless_time_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (found_c && kind_c == WIN_SEAMLESS)
      |-> (EW'(bk_col_ok_i[{q_rank_i[idx_c], q_bank_i[idx_c]}]) <= min_col));
  // R2: a decision request is acknowledged one edge later
  p_done_follows_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    eval_i |=> done_o);
  // R2: without a request the registered decision holds
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !eval_i |=> (!done_o && $stable(pick_found_o) && $stable(pick_idx_o)));
endmodule

// File: tb/sim_frf_pick_sel.sv
`timescale 1ns/1ps
module sim_frf_pick_sel;
  localparam int QD = 4, NR = 2, BPR = 2, ROW_W = 2, TW = 8;
  localparam int RW = 1, BW = 1, NB = 4, QW = 2;

  logic clk = 1'b0;
  logic rst_n, eval_i;
  logic [QD-1:0]            q_valid;
  logic [QD-1:0][RW-1:0]    q_rank;
  logic [QD-1:0][BW-1:0]    q_bank;
  logic [QD-1:0][ROW_W-1:0] q_row;
  logic [NR-1:0]            rank_avail;
  logic [NB-1:0]            bk_open;
  logic [NB-1:0][ROW_W-1:0] bk_row;
  logic [NB-1:0][TW-1:0]    bk_col, bk_act, bk_pre;
  logic [TW-1:0] now_t, busy_t, tcl, trcd, trp, tcs, trtw;
  logic dir_sw, for_wr;
  logic pick_found, done;
  logic [QW-1:0] pick_idx;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  frf_pick_sel #(.QD(QD), .NR(NR), .BPR(BPR), .ROW_W(ROW_W), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .q_valid_i(q_valid), .q_rank_i(q_rank),
    .q_bank_i(q_bank), .q_row_i(q_row), .rank_avail_i(rank_avail), .bk_open_i(bk_open),
    .bk_row_i(bk_row), .bk_col_ok_i(bk_col), .bk_act_ok_i(bk_act), .bk_pre_ok_i(bk_pre),
    .now_i(now_t), .bus_busy_i(busy_t), .t_cl_i(tcl), .t_rcd_i(trcd), .t_rp_i(trp),
    .t_cs_i(tcs), .t_rtw_i(trtw), .dir_switch_i(dir_sw), .for_writes_i(for_wr),
    .pick_found_o(pick_found), .pick_idx_o(pick_idx), .done_o(done));

  task automatic check_pick(input string req, input bit ef, input int ei);
    checks++;
    if (pick_found !== ef || (ef && int'(pick_idx) != ei)) begin
      errors++;
      $display("FAIL %s: found=%0d idx=%0d, expected found=%0d idx=%0d",
               req, pick_found, pick_idx, ef, ei);
    end
  endtask

  task automatic check_val(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d, expected %0d", req, got, exp);
    end
  endtask

  task automatic clear_all();
    q_valid = '0; q_rank = '0; q_bank = '0; q_row = '0; rank_avail = '1;
    bk_open = '0; bk_row = '0; bk_col = '0; bk_act = '0; bk_pre = '0;
    now_t = 8'd10; busy_t = 8'd20; tcl = 8'd4; trcd = 8'd3; trp = 8'd2;
    tcs = 8'd2; trtw = 8'd1; dir_sw = 1'b0; for_wr = 1'b0;
  endtask

  task automatic put_entry(input int i, input int r, input int b, input int row);
    q_valid[i] = 1'b1; q_rank[i] = RW'(r); q_bank[i] = BW'(b); q_row[i] = ROW_W'(row);
  endtask

  task automatic put_bank(input int id, input bit op, input int row,
                          input int col, input int act, input int pre);
    bk_open[id] = op; bk_row[id] = ROW_W'(row);
    bk_col[id] = TW'(col); bk_act[id] = TW'(act); bk_pre[id] = TW'(pre);
  endtask

  // inputs are set at a falling edge; outputs are read at the next falling edge
  task automatic do_eval();
    eval_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    eval_i = 1'b0;
  endtask

  task automatic eval_expect(input string req, input bit ef, input int ei);
    do_eval();
    check_pick(req, ef, ei);
  endtask

  // R2: outputs stay put and done stays low while eval_i is low
  task automatic hold_check();
    bit f0; int i0;
    f0 = pick_found; i0 = int'(pick_idx);
    check_val("R2 done after eval", int'(done), 1);
    q_valid = ~q_valid; rank_avail = ~rank_avail; now_t = now_t + 8'd3;
    @(posedge clk);
    @(negedge clk);
    check_pick("R2 hold while idle", f0, i0);
    check_val("R2 done idle", int'(done), 0);
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // class ranking model: 0 seamless hit, 1 hidden miss, 2 waiting hit,
  // 3 plain earliest miss, 4 not a candidate; lowest class, then lowest index
  task automatic ref_pick(output bit ef, output int ei, output int ecls);
    int w, hw, best, bi, first_miss, b, c;
    int a_at[NB]; int c_at[NB]; bit wt[NB]; bit rd[NB];
    bit any_seam; int lo;
    w  = imax(int'(busy_t) + (dir_sw ? (for_wr ? ((trtw < tcs) ? int'(trtw) : int'(tcs))
                                                : int'(tcs)) : 0) - int'(tcl), int'(now_t));
    hw = imax(w - int'(trcd), int'(now_t));
    for (int k = 0; k < NB; k++) begin
      a_at[k] = bk_open[k] ? imax(int'(bk_pre[k]), int'(now_t)) + int'(trp)
                           : imax(int'(bk_act[k]), int'(now_t));
      c_at[k] = imax(int'(bk_col[k]), a_at[k] + int'(trcd));
      wt[k] = 1'b0;
    end
    for (int i = 0; i < QD; i++)
      if (q_valid[i]) wt[int'(q_rank[i]) * BPR + int'(q_bank[i])] = 1'b1;
    any_seam = 1'b0; lo = 1 << 20;
    for (int k = 0; k < NB; k++) begin
      if (wt[k] && c_at[k] <= w) any_seam = 1'b1;
      if (wt[k] && a_at[k] < lo) lo = a_at[k];
    end
    for (int k = 0; k < NB; k++)
      rd[k] = any_seam ? (wt[k] && c_at[k] <= w) : (wt[k] && a_at[k] == lo);
    best = 4; bi = 0; first_miss = -1;
    for (int i = 0; i < QD; i++) begin
      if (q_valid[i] && rank_avail[q_rank[i]]) begin
        b = int'(q_rank[i]) * BPR + int'(q_bank[i]);
        if (bk_open[b] && bk_row[b] == q_row[i]) c = (int'(bk_col[b]) <= w) ? 0 : 2;
        else if (first_miss < 0 && rd[b]) begin
          first_miss = i;
          c = (a_at[b] <= hw) ? 1 : 3;
        end else c = 4;
        if (c < best) begin best = c; bi = i; end
      end
    end
    ef = (best < 4); ei = bi; ecls = best;
  endtask

  initial begin
    bit ef; int ei, ecls;
    string tag;
    eval_i = 1'b0;
    clear_all();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_val("R1 found in reset", int'(pick_found), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_val("R1 found after reset", int'(pick_found), 0);
    check_val("R1 idx after reset", int'(pick_idx), 0);
    check_val("R1 done after reset", int'(done), 0);

    // R6: first seamless hit wins over an earlier waiting hit (window 16)
    clear_all();
    put_bank(0, 1, 1, 18, 0, 0); put_bank(1, 1, 1, 16, 0, 0); put_bank(2, 1, 1, 12, 0, 0);
    put_entry(0, 0, 0, 1); put_entry(1, 0, 1, 1); put_entry(2, 1, 0, 1);
    eval_expect("R6 first seamless hit", 1, 1);
    hold_check();
    clear_all();
    put_bank(0, 1, 1, 18, 0, 0); put_bank(1, 1, 1, 17, 0, 0); put_bank(2, 1, 1, 12, 0, 0);
    put_entry(0, 0, 0, 1); put_entry(1, 0, 1, 1); put_entry(2, 1, 0, 1);
    eval_expect("R6 boundary col 17 over window 16", 1, 2);

    // R3: busy 2 + 0 - t_cl 9 saturates, window becomes now = 10
    clear_all();
    busy_t = 8'd2; tcl = 8'd9;
    put_bank(0, 1, 1, 11, 0, 0); put_bank(1, 1, 1, 10, 0, 0);
    put_entry(0, 0, 0, 1); put_entry(1, 0, 1, 1);
    eval_expect("R3 saturated window", 1, 1);

    // R4: read switch window 18, write switch window 17
    clear_all();
    put_bank(0, 1, 1, 18, 0, 0); put_bank(1, 1, 1, 17, 0, 0);
    put_entry(0, 0, 0, 1); put_entry(1, 0, 1, 1);
    dir_sw = 1'b1; for_wr = 1'b0;
    eval_expect("R4 read turnaround uses t_cs", 1, 0);
    dir_sw = 1'b1; for_wr = 1'b1;
    eval_expect("R4 write turnaround uses min(t_rtw,t_cs)", 1, 1);
    trtw = 8'd3;
    eval_expect("R4 write turnaround capped by t_cs", 1, 0);
    dir_sw = 1'b0; trtw = 8'd1; bk_col[1] = 8'd16;
    eval_expect("R4 no switch adds nothing", 1, 1);

    // R5: unavailable rank skipped
    clear_all();
    put_entry(0, 1, 0, 1); put_entry(1, 1, 1, 1);
    put_bank(2, 1, 1, 0, 0, 0); put_bank(3, 1, 1, 0, 0, 0);
    rank_avail = 2'b01;
    eval_expect("R5 all ranks busy", 0, 0);
    rank_avail = 2'b11;
    eval_expect("R5 rank freed", 1, 0);

    // R9: hidden miss beats waiting hit
    clear_all();
    put_bank(0, 1, 1, 20, 0, 0); put_bank(1, 0, 0, 0, 12, 0);
    put_entry(0, 0, 0, 1); put_entry(1, 0, 1, 2);
    eval_expect("R9 hidden miss over waiting hit", 1, 1);
    // R9: non-hidden miss loses in both orders (window 14, hidden limit 11)
    clear_all();
    busy_t = 8'd18;
    put_bank(0, 1, 1, 20, 0, 12); put_bank(1, 0, 0, 0, 12, 0);
    put_entry(0, 0, 0, 1); put_entry(1, 0, 1, 2);
    eval_expect("R9 waiting hit over later plain miss", 1, 0);
    q_valid = '0;
    put_entry(0, 0, 1, 2); put_entry(1, 0, 0, 1);
    eval_expect("R9 waiting hit over earlier plain miss", 1, 1);

    // R10: tie on activate time, oldest entry wins
    clear_all();
    busy_t = 8'd18;
    put_bank(2, 0, 0, 0, 12, 0); put_bank(3, 0, 0, 0, 12, 0);
    put_entry(0, 1, 1, 0); put_entry(1, 1, 0, 0);
    eval_expect("R10 tie oldest first", 1, 0);

    // R8: idle bank with earliest activate is not in the ready set
    clear_all();
    put_bank(0, 0, 0, 0, 0, 0); put_bank(1, 0, 0, 30, 14, 0);
    put_entry(0, 0, 1, 0);
    eval_expect("R8 idle bank excluded", 1, 0);
    // R8: seamless bank beats a bank with earlier activate
    clear_all();
    put_bank(2, 0, 0, 30, 11, 0); put_bank(1, 0, 0, 0, 12, 0);
    put_entry(0, 1, 0, 0); put_entry(1, 0, 1, 0);
    eval_expect("R8 seamless bank first", 1, 1);

    // R7: open bank pays precharge time before activate
    clear_all();
    put_bank(0, 1, 0, 0, 0, 12); put_bank(1, 0, 0, 0, 13, 0);
    put_entry(0, 0, 0, 1); put_entry(1, 0, 1, 0);
    eval_expect("R7 precharge term in activate time", 1, 1);

    // random sweep against the class model
    for (int n = 0; n < 3000; n++) begin
      q_valid = QD'($urandom);
      for (int i = 0; i < QD; i++) begin
        q_rank[i] = RW'($urandom); q_bank[i] = BW'($urandom); q_row[i] = ROW_W'($urandom);
      end
      rank_avail = ($urandom % 4 == 0) ? NR'($urandom) : '1;
      for (int k = 0; k < NB; k++) begin
        bk_open[k] = 1'($urandom); bk_row[k] = ROW_W'($urandom);
        bk_col[k] = TW'($urandom % 24); bk_act[k] = TW'($urandom % 24);
        bk_pre[k] = TW'($urandom % 24);
      end
      now_t = TW'($urandom % 16); busy_t = TW'($urandom % 40);
      tcl = TW'($urandom % 10); trcd = TW'($urandom % 8); trp = TW'($urandom % 6);
      tcs = TW'($urandom % 4); trtw = TW'($urandom % 4);
      dir_sw = ($urandom % 3 == 0); for_wr = 1'($urandom);
      ref_pick(ef, ei, ecls);
      case (ecls)
        0:       tag = "R6 random seamless hit";
        1:       tag = "R9 random hidden miss";
        2:       tag = "R9 random waiting hit";
        3:       tag = "R10 random earliest miss";
        default: tag = "R5 random none eligible";
      endcase
      eval_expect(tag, ef, ei);
      if (n % 100 == 0) hold_check();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule